// File: doc/BRIEF.md
# Banked Cartridge ROM Controller

This block extends the address of a cartridge ROM that is larger than the window the host CPU can see. The cartridge bus carries a 14-bit offset, which covers one 16 KB block. The ROM is split into such blocks. The block that appears in the window is chosen by a small latch inside the cartridge, and the CPU loads that latch by writing to any address inside the ROM window. Reads inside the window return ROM data. Writes never enable the ROM. Instead, the written byte's two lowest bits select the next block.

The full ROM address is formed from three parts. A host-side half-select bit is the most significant bit. The latched 2-bit block number comes next. The 14-bit bus offset fills the low bits. Together they give 17 bits, which addresses 128 KB. Reset selects block 0, so code that enters the cartridge after reset, an interrupt or a service call finds the expected block. The bus handshake is a plain strobe: a cycle counts while the second-phase clock is high and the window select is asserted. There is no back-pressure, because the ROM must answer every access in the cycle it is made.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While reset is low, and after it is released, the block latch holds 0. The next read therefore drives rom_addr[15:14] = 2'b00.
- R2: A rising clock edge with phi2=1, win_sel=1 and cpu_rnw=0 loads cpu_data[1:0] into the block latch. cpu_data[7:2] has no effect.
- R3: A write made with win_sel=0, or with phi2=0, leaves the block latch unchanged.
- R4: rom_oe_n is 0 exactly when phi2=1, win_sel=1 and cpu_rnw=1. At all other times it is 1.
- R5: During a write cycle (cpu_rnw=0), rom_oe_n is 1, so the ROM never drives the data bus while the latch is written.
- R6: rom_addr[13:0] equals cpu_addr[13:0] at all times.
- R7: rom_addr[15:14] equals the latched block number and rom_addr[16] equals host_half. The address field order is {half, block, offset}.
- R8: Read cycles never change the block latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the latch samples on its rising edge |
| rst_n | input | 1 | Active-low reset; selects block 0 |
| phi2 | input | 1 | Second-phase qualifier of the CPU bus cycle |
| win_sel | input | 1 | High when the CPU addresses the ROM window |
| cpu_rnw | input | 1 | 1 for a read, 0 for a write |
| cpu_addr | input | 14 | Offset inside the 16 KB window |
| cpu_data | input | 8 | Write data from the CPU; bits 1:0 carry the block number |
| host_half | input | 1 | Host paging bit choosing one half of the device |
| rom_addr | output | 17 | Full ROM address {half, block, offset} |
| rom_oe_n | output | 1 | Active-low ROM output enable |

## Verification
Some properties are checked by assertions on every cycle. The enable is never asserted in a write cycle, and it follows the qualified read decode. The latch stays stable unless a qualified write occurs, and after such a write it holds the written low data bits. The address lines carry the offset and the host bit unchanged. Other behaviour only shows up in the bench's scenarios. These include writes outside the window or outside phi2 being ignored, and data bits 7:2 having no effect. They also include each read after a block change returning data tagged with the new block, and the reset value seen through the first read.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int OFS_W  = 14;
  localparam int BLK_W  = 2;
  localparam int DATA_W = 8;
  localparam int ROM_AW = 1 + BLK_W + OFS_W;

  typedef struct packed {
    logic             half;
    logic [BLK_W-1:0] blk;
    logic [OFS_W-1:0] ofs;
  } rom_addr_t;
endpackage

// File: rtl/cbk_decode.sv
module cbk_decode (
  input  logic phi2,
  input  logic win_sel,
  input  logic cpu_rnw,
  output logic rd_en,
  output logic wr_stb
);
  logic cyc_act;
  always_comb begin
    cyc_act = phi2 & win_sel;
    rd_en   = cyc_act & cpu_rnw;
    wr_stb  = cyc_act & ~cpu_rnw;
  end
endmodule

// File: rtl/cbk_block_reg.sv
module cbk_block_reg #(
  parameter int BLK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [BLK_W-1:0] wr_blk,
  output logic [BLK_W-1:0] blk_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '0;
    else if (wr_stb) blk_q <= wr_blk;
  end

  // R1
  reset_block_zero_chk: assert property (@(posedge clk) !rst_n |=> blk_q == '0);
  // R3
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(blk_q));
  // R2
  load_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> blk_q == $past(wr_blk));
endmodule

// File: rtl/cbk_addr_map.sv
module cbk_addr_map
  import cart_bank_pkg::*;
#(
  parameter int O_W = OFS_W,
  parameter int B_W = BLK_W,
  localparam int A_W = 1 + B_W + O_W
) (
  input  logic           half,
  input  logic [B_W-1:0] blk,
  input  logic [O_W-1:0] ofs,
  output logic [A_W-1:0] addr
);
  assign addr = {half, blk, ofs};
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int O_W = OFS_W,
  parameter int B_W = BLK_W,
  parameter int D_W = DATA_W,
  localparam int A_W = 1 + B_W + O_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           phi2,
  input  logic           win_sel,
  input  logic           cpu_rnw,
  input  logic [O_W-1:0] cpu_addr,
  input  logic [D_W-1:0] cpu_data,
  input  logic           host_half,
  output logic [A_W-1:0] rom_addr,
  output logic           rom_oe_n
);
  logic           rd_en;
  logic           wr_stb;
  logic [B_W-1:0] blk_q;

  cbk_decode dec_i (
    .phi2(phi2), .win_sel(win_sel), .cpu_rnw(cpu_rnw),
    .rd_en(rd_en), .wr_stb(wr_stb)
  );

  cbk_block_reg #(.BLK_W(B_W)) blk_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .wr_blk(cpu_data[B_W-1:0]), .blk_q(blk_q)
  );

  cbk_addr_map #(.O_W(O_W), .B_W(B_W)) map_i (
    .half(host_half), .blk(blk_q), .ofs(cpu_addr), .addr(rom_addr)
  );

  assign rom_oe_n = ~rd_en;

  // R5
  no_oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rnw |-> rom_oe_n);
  // R4
  oe_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (phi2 && win_sel));
  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[O_W-1:0] == cpu_addr);
  // R7
  half_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[A_W-1] == host_half);
  // R8
  read_keeps_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rnw |=> rom_addr[O_W+B_W-1:O_W] == $past(rom_addr[O_W+B_W-1:O_W]));
endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0, win_sel = 1'b0, cpu_rnw = 1'b1, host_half = 1'b0;
  logic [13:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [16:0] rom_addr;
  logic        rom_oe_n;
  int checks = 0, errors = 0;
  logic [1:0] blk_exp = 2'b00;

  always #10 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .win_sel(win_sel), .cpu_rnw(cpu_rnw),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .host_half(host_half),
    .rom_addr(rom_addr), .rom_oe_n(rom_oe_n)
  );

  // Model ROM: each word is tagged with its block and half
  function automatic logic [7:0] rom_word(input logic [16:0] a);
    return {a[16], a[15:14], a[4:0]};
  endfunction

  function automatic logic [16:0] exp_addr(input logic h, input logic [1:0] b,
                                           input logic [13:0] o);
    return {h, b, o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [13:0] a, input logic h, input string req);
    @(negedge clk);
    phi2 = 1'b1; win_sel = 1'b1; cpu_rnw = 1'b1; cpu_addr = a; host_half = h;
    #2;
    chk("R4 read oe", {31'd0, rom_oe_n}, 32'd0);
    chk(req, {15'd0, rom_addr}, {15'd0, exp_addr(h, blk_exp, a)});
    chk("R7 tagged data", {24'd0, rom_word(rom_addr)},
        {24'd0, rom_word(exp_addr(h, blk_exp, a))});
    @(negedge clk);
    phi2 = 1'b0; win_sel = 1'b0;
    #2;
    chk("R4 idle oe", {31'd0, rom_oe_n}, 32'd1);
  endtask

  task automatic do_write(input logic [13:0] a, input logic [7:0] d,
                          input logic ph, input logic ws);
    @(negedge clk);
    phi2 = ph; win_sel = ws; cpu_rnw = 1'b0; cpu_addr = a; cpu_data = d;
    #2;
    chk("R5 write oe", {31'd0, rom_oe_n}, 32'd1);
    chk("R6 offset on write", {18'd0, rom_addr[13:0]}, {18'd0, a});
    if (ph && ws) blk_exp = d[1:0];
    @(negedge clk);
    phi2 = 1'b0; win_sel = 1'b0; cpu_rnw = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset oe", {31'd0, rom_oe_n}, 32'd1);
    chk("R1 reset block", {30'd0, rom_addr[15:14]}, 32'd0);
    rst_n = 1'b1;
    do_read(14'h0000, 1'b0, "R1 first read block 0");
    // R2 each block in turn, upper data bits set to junk
    for (int b = 0; b < 4; b++) begin
      do_write(14'h3FFF, {6'b101101, 2'(b)}, 1'b1, 1'b1);
      do_read(14'h1234, 1'b1, "R2 block after write");
    end
    // R3 writes outside window and outside phi2 ignored
    do_write(14'h0001, 8'h02, 1'b1, 1'b1);
    do_write(14'h0002, 8'h01, 1'b1, 1'b0);
    do_read(14'h2000, 1'b0, "R3 no window write ignored");
    do_write(14'h0003, 8'h03, 1'b0, 1'b1);
    do_read(14'h2001, 1'b0, "R3 no phi2 write ignored");
    // R8 back-to-back reads keep block
    do_read(14'h3FFF, 1'b1, "R8 read keeps block");
    do_read(14'h0000, 1'b0, "R8 read keeps block");
    // R6 R7 random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      if (r[0]) do_read(14'($urandom), r[1], "R7 random read");
      else      do_write(14'($urandom), 8'($urandom), r[2] | r[3], r[4] | r[5]);
    end
    // R1 reset mid-run restores block 0
    do_write(14'h0100, 8'h03, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b0; blk_exp = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    do_read(14'h0100, 1'b0, "R1 block 0 after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule